// File: doc/BRIEF.md
# Conditional Branch and Stack Unit

This block resolves the flow-control instructions of an 8-bit processor. It is handed an already decoded operation together with its condition field, the one or two immediate bytes, the four condition flags, the loop-count register and the current program counter and stack pointer. From these it works out whether the branch is taken. It then produces the next program counter, the next stack pointer and the next loop-count value, and it reports whether the branch was taken.

Absolute jumps, relative jumps and the decrement-and-branch loop complete in a single cycle. A call whose condition holds writes its return address to memory, one byte per cycle over a byte-wide port. A return whose condition holds reads its return address back the same way. The supplied program counter must already point at the byte after the whole instruction. That value is used as the relative base, as the pushed return address and as the "not taken" result.

Top module: `flow_ctl_unit`

## Requirements
- R1: The 3-bit condition code picks one flag test: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity/overflow clear, 5 parity/overflow set, 6 sign clear, 7 sign set. A conditional absolute jump (op 0) or call (op 3) or return (op 4) is taken only when that test holds; the unconditional forms (cond_en_i low) are always taken.
- R2: A conditional relative jump (op 1) looks only at code bits 1:0, so bit 2 has no effect and only the four zero/carry tests apply.
- R3: A taken relative jump or loop branch sets the program counter to pc_i plus imm_lo_i sign-extended (-128..+127), modulo 2^16.
- R4: The loop operation (op 2) outputs b_i minus one (modulo 256) and branches only when that new value is non-zero; cond_en_i, the condition code and the flags have no effect on it.
- R5: A taken absolute jump sets the program counter to {imm_hi_i, imm_lo_i}. Any operation that is not taken returns pc_o = pc_i and sp_o = sp_i.
- R6: A taken call (op 3) sets sp_o = sp_i - 2 and pc_o = {imm_hi_i, imm_lo_i}. It writes pc_i[7:0] at address sp_i-2 in the first memory cycle and pc_i[15:8] at sp_i-1 in the second.
- R7: A taken return (op 4) reads address sp_i in the first memory cycle as the low byte and sp_i+1 in the second as the high byte, then sets pc_o to that word and sp_o = sp_i + 2.
- R8: done_o is a one-cycle pulse. It comes one cycle after an accepted start for operations with no memory traffic, and three cycles after for a taken call or return. busy_o is high from acceptance through the done cycle, and start_i has no effect while busy_o is high.
- R9: After reset, done_o, busy_o, mem_req_o, taken_o, pc_o, sp_o and b_o are all zero.
- R10: taken_o, valid while done_o is high and held after, is 1 exactly when the program counter was redirected. An operation that is not taken issues no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (accepted when not busy) |
| op_i | input | 3 | 0 absolute jump, 1 relative jump, 2 loop, 3 call, 4 return |
| cond_en_i | input | 1 | Operation is conditional |
| cc_i | input | 3 | Condition code |
| imm_lo_i | input | 8 | Low immediate byte / displacement |
| imm_hi_i | input | 8 | High immediate byte |
| flag_s_i | input | 1 | Sign flag |
| flag_z_i | input | 1 | Zero flag |
| flag_pv_i | input | 1 | Parity/overflow flag |
| flag_c_i | input | 1 | Carry flag |
| b_i | input | 8 | Loop-count register |
| pc_i | input | 16 | Address of the byte after the instruction |
| sp_i | input | 16 | Stack pointer |
| mem_req_o | output | 1 | Memory cycle active |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 16 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte, sampled at the edge ending the cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch was taken |
| pc_o | output | 16 | Next program counter |
| sp_o | output | 16 | Next stack pointer |
| b_o | output | 8 | Next loop-count value |

## Verification
In the loop operation the decrement and the branch decision resolve in the same cycle. The decision has to be made on the decremented value and not on b_i. The bench provokes this with b_i = 1, which must decrement to zero and fall through, and with b_i = 0, which must wrap to 255 and branch. It also sets cond_en_i with a failing condition, to show the loop ignores it. Each case is judged on b_o, taken_o and pc_o together in the done cycle.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;
  typedef enum logic [2:0] {
    OP_JP   = 3'd0,
    OP_JR   = 3'd1,
    OP_LOOP = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } fc_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LO,
    SQ_HI,
    SQ_FIN
  } sq_state_e;
endpackage

// File: rtl/fc_cond_eval.sv
module fc_cond_eval (
  input  logic [2:0] cc_i,
  input  logic       short_i,
  input  logic       flag_s_i,
  input  logic       flag_z_i,
  input  logic       flag_pv_i,
  input  logic       flag_c_i,
  output logic       met_o
);
  logic [2:0] sel;
  logic       flag;

  // short form: only zero/carry tests reachable
  assign sel = short_i ? {1'b0, cc_i[1:0]} : cc_i;

  always_comb begin
    unique case (sel[2:1])
      2'b00:   flag = flag_z_i;
      2'b01:   flag = flag_c_i;
      2'b10:   flag = flag_pv_i;
      default: flag = flag_s_i;
    endcase
  end

  assign met_o = sel[0] ? flag : ~flag;
endmodule

// File: rtl/fc_target.sv
module fc_target #(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W
) (
  input  logic [AW-1:0]     pc_i,
  input  logic [DATA_W-1:0] imm_lo_i,
  input  logic [DATA_W-1:0] imm_hi_i,
  output logic [AW-1:0]     abs_o,
  output logic [AW-1:0]     rel_o
);
  logic [AW-1:0] disp_ext;

  assign disp_ext = {{DATA_W{imm_lo_i[DATA_W-1]}}, imm_lo_i};
  assign abs_o    = {imm_hi_i, imm_lo_i};
  assign rel_o    = pc_i + disp_ext;
endmodule

// File: rtl/fc_stack_seq.sv
module fc_stack_seq
  import flow_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     word_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [AW-1:0]     word_o,
  output logic              busy_o,
  output logic              fin_o
);
  sq_state_e         state_q, state_d;
  logic [AW-1:0]     base_q, word_q;
  logic              we_q;
  logic [DATA_W-1:0] lo_q, hi_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (start_i) state_d = (push_i || pop_i) ? SQ_LO : SQ_FIN;
      SQ_LO:   state_d = SQ_HI;
      SQ_HI:   state_d = SQ_FIN;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      base_q  <= '0;
      word_q  <= '0;
      we_q    <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_IDLE && start_i) begin
        base_q <= base_i;
        word_q <= word_i;
        we_q   <= push_i;
      end
      if (state_q == SQ_LO && !we_q) lo_q <= mem_rdata_i;
      if (state_q == SQ_HI && !we_q) hi_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = (state_q == SQ_LO) || (state_q == SQ_HI);
  assign mem_we_o    = mem_req_o && we_q;
  assign mem_addr_o  = base_q + ((state_q == SQ_HI) ? AW'(1) : AW'(0));
  assign mem_wdata_o = (state_q == SQ_HI) ? word_q[AW-1:DATA_W] : word_q[DATA_W-1:0];
  assign word_o      = {hi_q, lo_q};
  assign busy_o      = state_q != SQ_IDLE;
  assign fin_o       = state_q == SQ_FIN;
endmodule

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit
  import flow_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              cond_en_i,
  input  logic [2:0]        cc_i,
  input  logic [DATA_W-1:0] imm_lo_i,
  input  logic [DATA_W-1:0] imm_hi_i,
  input  logic              flag_s_i,
  input  logic              flag_z_i,
  input  logic              flag_pv_i,
  input  logic              flag_c_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [AW-1:0]     pc_o,
  output logic [AW-1:0]     sp_o,
  output logic [DATA_W-1:0] b_o
);
  fc_op_e            op;
  logic              cond_met, accept;
  logic [AW-1:0]     abs_tgt, rel_tgt, pop_word;
  logic              taken_d, push_d, pop_d;
  logic [AW-1:0]     pc_d, sp_d, stk_base;
  logic [DATA_W-1:0] b_d, b_dec;

  logic              taken_q, pop_sel_q;
  logic [AW-1:0]     pc_q, sp_q;
  logic [DATA_W-1:0] b_q;

  assign op     = fc_op_e'(op_i);
  assign b_dec  = b_i - DATA_W'(1);
  assign accept = start_i && !busy_o;

  fc_cond_eval u_cond (
    .cc_i      (cc_i),
    .short_i   (op == OP_JR),
    .flag_s_i  (flag_s_i),
    .flag_z_i  (flag_z_i),
    .flag_pv_i (flag_pv_i),
    .flag_c_i  (flag_c_i),
    .met_o     (cond_met)
  );

  fc_target #(.DATA_W(DATA_W)) u_tgt (
    .pc_i     (pc_i),
    .imm_lo_i (imm_lo_i),
    .imm_hi_i (imm_hi_i),
    .abs_o    (abs_tgt),
    .rel_o    (rel_tgt)
  );

  always_comb begin
    taken_d  = 1'b0;
    push_d   = 1'b0;
    pop_d    = 1'b0;
    pc_d     = pc_i;
    sp_d     = sp_i;
    b_d      = b_i;
    stk_base = sp_i;
    unique case (op)
      OP_JP: begin
        taken_d = !cond_en_i || cond_met;
        if (taken_d) pc_d = abs_tgt;
      end
      OP_JR: begin
        taken_d = !cond_en_i || cond_met;
        if (taken_d) pc_d = rel_tgt;
      end
      OP_LOOP: begin
        b_d     = b_dec;
        taken_d = b_dec != '0;
        if (taken_d) pc_d = rel_tgt;
      end
      OP_CALL: begin
        taken_d  = !cond_en_i || cond_met;
        push_d   = taken_d;
        stk_base = sp_i - AW'(2);
        if (taken_d) begin
          pc_d = abs_tgt;
          sp_d = stk_base;
        end
      end
      OP_RET: begin
        taken_d = !cond_en_i || cond_met;
        pop_d   = taken_d;
        if (taken_d) sp_d = sp_i + AW'(2);
      end
      default: ;
    endcase
  end

  fc_stack_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .push_i      (push_d),
    .pop_i       (pop_d),
    .base_i      (stk_base),
    .word_i      (pc_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .word_o      (pop_word),
    .busy_o      (busy_o),
    .fin_o       (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q   <= 1'b0;
      pop_sel_q <= 1'b0;
      pc_q      <= '0;
      sp_q      <= '0;
      b_q       <= '0;
    end else if (accept) begin
      taken_q   <= taken_d;
      pop_sel_q <= pop_d;
      pc_q      <= pc_d;
      sp_q      <= sp_d;
      b_q       <= b_d;
    end
  end

  assign taken_o = taken_q;
  assign pc_o    = pop_sel_q ? pop_word : pc_q;
  assign sp_o    = sp_q;
  assign b_o     = b_q;
endmodule

// File: rtl/flow_ctl_unit_chk.sv
module flow_ctl_unit_chk #(
  parameter int DATA_W = 8,
  localparam int AW = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [AW-1:0]     pc_o,
  input logic [AW-1:0]     sp_o
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_mem_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_push_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o))
      |-> mem_addr_o == $past(mem_addr_o) + AW'(1));

  assert_pop_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && $past(mem_req_o && !mem_we_o))
      |-> mem_addr_o == $past(mem_addr_o) + AW'(1));

  assert_call_sp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_req_o && mem_we_o)) |-> sp_o == $past(mem_addr_o, 2));

  assert_ret_sp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_req_o && !mem_we_o)) |-> sp_o == $past(mem_addr_o) + AW'(1));

  assert_ret_pc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(mem_req_o && !mem_we_o))
      |-> pc_o == {$past(mem_rdata_i), $past(mem_rdata_i, 2)});
endmodule

bind flow_ctl_unit flow_ctl_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pc_o        (pc_o),
  .sp_o        (sp_o)
);

// File: tb/flow_ctl_unit_tb_top.sv
module flow_ctl_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, cen = 1'b0;
  logic [2:0]  op = '0, cc = '0;
  logic [7:0]  lo = '0, hi = '0, b = '0;
  logic        fs = 1'b0, fz = 1'b0, fp = 1'b0, fc = 1'b0;
  logic [15:0] pc = '0, sp = '0;
  logic        mreq, mwe, busy, done, taken;
  logic [15:0] maddr, pco, spo;
  logic [7:0]  mwd, mrd, bo;

  logic [7:0]  mem [256];
  logic [15:0] wr_addr [4];
  logic [7:0]  wr_data [4];
  int          wr_cnt = 0;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  assign mrd = mem[maddr[7:0]];

  always @(posedge clk) begin
    if (mreq && mwe) begin
      mem[maddr[7:0]] <= mwd;
      if (wr_cnt < 4) begin
        wr_addr[wr_cnt] <= maddr;
        wr_data[wr_cnt] <= mwd;
      end
      wr_cnt <= wr_cnt + 1;
    end
  end

  flow_ctl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .cond_en_i(cen), .cc_i(cc),
    .imm_lo_i(lo), .imm_hi_i(hi), .flag_s_i(fs), .flag_z_i(fz), .flag_pv_i(fp), .flag_c_i(fc),
    .b_i(b), .pc_i(pc), .sp_i(sp), .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd), .busy_o(busy), .done_o(done), .taken_o(taken),
    .pc_o(pco), .sp_o(spo), .b_o(bo)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        cen;
    logic [2:0]  cc;
    logic [3:0]  flg;  // {s,z,pv,c}
    logic [7:0]  lo, hi, b;
    logic [15:0] pc, sp;
    logic [15:0] e_pc;
    logic [7:0]  e_b;
    logic        e_tk;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 3'd0, 4'b0000, 8'h78, 8'h56, 8'h11, 16'h1000, 16'h8000, 16'h5678, 8'h11, 1'b1}, // R5
    '{3'd0, 1'b1, 3'd1, 4'b1011, 8'h78, 8'h56, 8'h11, 16'h1000, 16'h8000, 16'h1000, 8'h11, 1'b0}, // R5 R1
    '{3'd0, 1'b1, 3'd7, 4'b1000, 8'h00, 8'hA0, 8'h11, 16'h1000, 16'h8000, 16'hA000, 8'h11, 1'b1}, // R1
    '{3'd1, 1'b0, 3'd0, 4'b0000, 8'h05, 8'h00, 8'h22, 16'h2000, 16'h8000, 16'h2005, 8'h22, 1'b1}, // R3
    '{3'd1, 1'b0, 3'd0, 4'b0000, 8'h80, 8'h00, 8'h22, 16'h2000, 16'h8000, 16'h1F80, 8'h22, 1'b1}, // R3
    '{3'd1, 1'b1, 3'd5, 4'b0100, 8'h10, 8'h00, 8'h22, 16'h2000, 16'h8000, 16'h2010, 8'h22, 1'b1}, // R2
    '{3'd1, 1'b1, 3'd6, 4'b0001, 8'h10, 8'h00, 8'h22, 16'h2000, 16'h8000, 16'h2000, 8'h22, 1'b0}, // R2
    '{3'd2, 1'b0, 3'd0, 4'b0000, 8'h10, 8'h00, 8'h01, 16'h3000, 16'h8000, 16'h3000, 8'h00, 1'b0}, // R4
    '{3'd2, 1'b0, 3'd0, 4'b0000, 8'hFE, 8'h00, 8'h00, 16'h3000, 16'h8000, 16'h2FFE, 8'hFF, 1'b1}, // R4
    '{3'd2, 1'b1, 3'd1, 4'b0000, 8'h7F, 8'h00, 8'h05, 16'h3000, 16'h8000, 16'h307F, 8'h04, 1'b1}, // R4
    '{3'd3, 1'b1, 3'd2, 4'b0001, 8'h00, 8'h90, 8'h33, 16'h4000, 16'h8000, 16'h4000, 8'h33, 1'b0}, // R6 R10
    '{3'd4, 1'b1, 3'd4, 4'b0010, 8'h00, 8'h00, 8'h33, 16'h4000, 16'h8000, 16'h4000, 8'h33, 1'b0}, // R7 R10
    '{3'd1, 1'b0, 3'd0, 4'b0000, 8'h7F, 8'h00, 8'h44, 16'hFFF0, 16'h8000, 16'h006F, 8'h44, 1'b1}  // R3
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [2:0] o, input logic ce, input logic [2:0] c, input logic [3:0] f,
                        input logic [7:0] l, input logic [7:0] h, input logic [7:0] bb,
                        input logic [15:0] p, input logic [15:0] s, output int lat);
    @(negedge clk);
    op = o; cen = ce; cc = c; {fs, fz, fp, fc} = f; lo = l; hi = h; b = bb; pc = p; sp = s;
    wr_cnt = 0;
    start = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end while (!done && lat < 20);
  endtask

  function automatic bit exp_cond(input logic [2:0] c, input logic [3:0] f);
    case (c)
      3'd0: return !f[2];
      3'd1: return f[2];
      3'd2: return !f[0];
      3'd3: return f[0];
      3'd4: return !f[1];
      3'd5: return f[1];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #1;
    check(!done && !busy && !mreq && !taken, "R9", {done, busy, mreq, taken}, 0);
    check(pco == 0 && spo == 0 && bo == 0, "R9", {pco, spo}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].op, VECS[i].cen, VECS[i].cc, VECS[i].flg, VECS[i].lo, VECS[i].hi,
             VECS[i].b, VECS[i].pc, VECS[i].sp, lat);
      check(lat == 1, "R8 latency", lat, 1);
      check(pco == VECS[i].e_pc, "R3/R4/R5 pc", pco, VECS[i].e_pc);
      check(spo == VECS[i].sp, "R5 sp", spo, VECS[i].sp);
      check(bo == VECS[i].e_b, "R4 b", bo, VECS[i].e_b);
      check(taken == VECS[i].e_tk, "R10 taken", taken, VECS[i].e_tk);
      check(wr_cnt == 0, "R10 no mem", wr_cnt, 0);
    end

    // R1 full condition table on conditional absolute jump
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        bit e;
        e = exp_cond(3'(c), 4'(f));
        launch(3'd0, 1'b1, 3'(c), 4'(f), 8'hCD, 8'hAB, 8'h00, 16'h0100, 16'h8000, lat);
        check(taken == e, "R1 cond", {c[7:0], f[7:0], 7'd0, taken}, e);
        check(pco == (e ? 16'hABCD : 16'h0100), "R1 pc", pco, e ? 16'hABCD : 16'h0100);
      end
    end

    // R6 taken call
    launch(3'd3, 1'b0, 3'd0, 4'b0000, 8'hEF, 8'hBE, 8'h00, 16'h4321, 16'h0100, lat);
    check(lat == 3, "R8 call latency", lat, 3);
    check(pco == 16'hBEEF && spo == 16'h00FE, "R6 pc/sp", {pco, spo}, {16'hBEEF, 16'h00FE});
    check(wr_cnt == 2 && wr_addr[0] == 16'h00FE && wr_data[0] == 8'h21, "R6 first write",
          {wr_addr[0], wr_data[0]}, {16'h00FE, 8'h21});
    check(wr_addr[1] == 16'h00FF && wr_data[1] == 8'h43, "R6 second write",
          {wr_addr[1], wr_data[1]}, {16'h00FF, 8'h43});
    check(taken, "R10 call taken", taken, 1);

    // R7 taken return reads back the same word
    launch(3'd4, 1'b0, 3'd0, 4'b0000, 8'h00, 8'h00, 8'h00, 16'h9000, 16'h00FE, lat);
    check(lat == 3, "R8 ret latency", lat, 3);
    check(pco == 16'h4321 && spo == 16'h0100, "R7 pc/sp", {pco, spo}, {16'h4321, 16'h0100});
    check(wr_cnt == 0, "R7 no write", wr_cnt, 0);

    // R6 stack wrap
    launch(3'd3, 1'b1, 3'd3, 4'b0001, 8'h00, 8'h20, 8'h00, 16'h5AA5, 16'h0001, lat);
    check(spo == 16'hFFFF, "R6 wrap sp", spo, 16'hFFFF);
    check(wr_addr[0] == 16'hFFFF && wr_addr[1] == 16'h0000, "R6 wrap addr",
          {wr_addr[0], wr_addr[1]}, {16'hFFFF, 16'h0000});
    check(wr_data[0] == 8'hA5 && wr_data[1] == 8'h5A, "R6 wrap data",
          {wr_data[0], wr_data[1]}, 16'hA55A);

    // R8 start while busy is ignored
    @(negedge clk);
    op = 3'd3; cen = 1'b0; lo = 8'h34; hi = 8'h12; pc = 16'h0777; sp = 16'h0080;
    wr_cnt = 0; start = 1'b1;
    @(negedge clk);
    op = 3'd0; lo = 8'hFF; hi = 8'hFF; pc = 16'h0000;  // held high while busy
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done && pco == 16'h1234 && spo == 16'h007E, "R8 busy ignore", pco, 16'h1234);
    repeat (3) @(negedge clk);
    check(!done && !busy && pco == 16'h1234, "R8 no extra op", {done, busy, pco}, 16'h1234);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule